// File: doc/BRIEF.md
# Serial Display Command Receiver

This block takes display commands from a host over three wires (enable, serial clock, serial data) and holds the result as a bank of segment bits and a set of drive-control fields. Each transfer begins with an 8-bit device address shifted in while enable is low. When enable rises, the frame that follows is accepted only if that address matched. The frame is shifted in while enable stays high. Nothing changes until enable falls. At that point the bit count and the final direction bit of the frame pick the destination: the lower display bank together with the control fields, or the upper display bank alone.

Two frame layouts are understood. The full layout is 40 bits and carries every control field. The shorter legacy layout is 32 bits and carries only the power-save and segment-blank bits. A lower-bank frame in the legacy layout switches the block into a compatibility state. In that state several control outputs are pinned to fixed values. A lower-bank frame in the full layout leaves that state. All three serial inputs are sampled through two-flop synchronizers into the system clock domain, and bits are taken on rising serial-clock edges. For that reason the serial clock may rest either low or high between transfers.

Top module: `ser_disp_cmd_rx`

## Requirements
- R1: The address is taken least significant bit first from the last 8 rising serial-clock edges seen while enable is low, and a frame is accepted only when that value is 0x44. A frame sent under any other address leaves every output unchanged.
- R2: A 40-bit frame whose bit 39 (the last bit sent) is 0 loads these fields, with bit k being the (k+1)-th bit sent:
  - `disp_o[27:0]` from bits 0..27 (bit 28 is a spacer);
  - `port_cfg_o` from bits 29..31, bit 29 landing in `port_cfg_o[0]`;
  - `duty_half_o` from bit 32;
  - `frame_div_o` from bits 33..35, bit 33 landing in `frame_div_o[0]`;
  - `ext_clk_o` from bit 36, `seg_off_o` from bit 37 and `pwr_save_o` from bit 38.
- R3: A 40-bit frame whose bit 39 is 1 loads `disp_o[53:28]` from bits 0..25 and leaves the lower bank and the control fields unchanged.
- R4: A 32-bit frame whose bit 31 is 0 loads these fields and sets `compat_o`; a lower-bank 40-bit frame (R2) clears `compat_o`:
  - `disp_o[27:0]` from bits 0..27;
  - `pwr_save_o` from bit 28;
  - `seg_off_o` from bit 29.
- R5: A 32-bit frame whose bit 31 is 1 loads `disp_o[53:28]` from bits 0..25 and leaves the lower bank and the control fields unchanged.
- R6: While `compat_o` is 1, these outputs are forced, whatever the stored full-layout settings are:
  - `port_cfg_o` = 000 (all shared pins act as segments);
  - `duty_half_o` = 1;
  - `frame_div_o` = 000 (the divide-by-384 code);
  - `ext_clk_o` = 0.
- R7: While the effective duty is static (`duty_half_o` = 0), `disp_o[27]` (segment bit 28) reads 0. The stored bit reappears once half duty is in effect.
- R8: A frame whose bit count is neither 40 nor 32 is discarded, and all outputs keep their previous values.
- R9: Transfers are received correctly whether the serial clock rests low or rests high between bits and between transfers.
- R10: No output changes while enable is still high, even after a complete frame has been shifted in. Updates follow the falling edge of enable.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_en_i | input | 1 | Serial enable: low for the address phase, high for the frame phase |
| ser_clk_i | input | 1 | Serial clock; bits are taken on its rising edge |
| ser_dat_i | input | 1 | Serial data |
| disp_o | output | 54 | Display bits; bit i is segment datum i+1 |
| port_cfg_o | output | 3 | Shared-pin function code |
| duty_half_o | output | 1 | Effective drive duty: 1 = half duty, 0 = static |
| frame_div_o | output | 3 | Frame-rate divisor code |
| ext_clk_o | output | 1 | Effective clock source: 1 = external clock, 0 = internal oscillator |
| seg_off_o | output | 1 | Blank all segments |
| pwr_save_o | output | 1 | Power-save request |
| compat_o | output | 1 | Legacy (32-bit) layout in effect |

## Verification
A miscounted frame, a lost address match or a wrong direction decode shows up at the ports within a few system clocks of enable falling. It appears either as a bank that failed to update or as a bank or control field that changed when it should not have. A stale or wrongly set compatibility flag is visible at once on the forced control outputs. A wrong duty setting shows on segment bit 28. Each transfer is followed by a comparison of every output against a model state kept in the bench. Transfers with bad addresses and bad lengths are sent so that state corrupted by a discarded frame is also detected.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  // Stored control fields of a full-layout lower-bank frame.
  typedef struct packed {
    logic [2:0] port_cfg;
    logic       duty_half;
    logic [2:0] frame_div;
    logic       ext_clk;
    logic       seg_off;
    logic       pwr_save;
  } sdc_ctrl_t;

  localparam logic [7:0] SDC_DEV_ADDR = 8'h44;

endpackage

// File: rtl/sdc_sync.sv
module sdc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  genvar g;
  for (g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/sdc_frame_rx.sv
module sdc_frame_rx #(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  DEV_ADDR = 8'h44,
  parameter int          FULL_LEN = 40,
  parameter int          CMP_LEN  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_s,
  input  logic                sck_s,
  input  logic                dat_s,
  output logic                commit_o,
  output logic                full_o,
  output logic [FULL_LEN-1:0] frame_o
);

  localparam int CNT_W = $clog2(FULL_LEN + 2);
  localparam int IDX_W = $clog2(FULL_LEN);
  localparam int AC_W  = $clog2(ADDR_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FULL_LEN);
  localparam logic [CNT_W-1:0] CNT_CMP  = CNT_W'(CMP_LEN);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FULL_LEN + 1);
  localparam logic [AC_W-1:0]  AC_DONE  = AC_W'(ADDR_W);

  logic                sck_d, en_d;
  logic                sck_rise, en_rise, en_fall;
  logic [ADDR_W-1:0]   addr_q, addr_n;
  logic [AC_W-1:0]     acnt_q, acnt_n;
  logic                match_q, match_n;
  logic [CNT_W-1:0]    bcnt_q, bcnt_n;
  logic [FULL_LEN-1:0] frame_q, frame_n;
  logic                commit_q, commit_n;
  logic                full_q, full_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      en_d  <= 1'b0;
    end else begin
      sck_d <= sck_s;
      en_d  <= en_s;
    end
  end

  assign sck_rise = sck_s & ~sck_d;
  assign en_rise  = en_s & ~en_d;
  assign en_fall  = ~en_s & en_d;

  always_comb begin
    addr_n   = addr_q;
    acnt_n   = acnt_q;
    match_n  = match_q;
    bcnt_n   = bcnt_q;
    frame_n  = frame_q;
    commit_n = 1'b0;
    full_n   = full_q;
    if (en_rise) begin
      bcnt_n  = '0;
      match_n = (acnt_q == AC_DONE) && (addr_q == DEV_ADDR);
    end else if (en_fall) begin
      commit_n = match_q && ((bcnt_q == CNT_FULL) || (bcnt_q == CNT_CMP));
      full_n   = (bcnt_q == CNT_FULL);
      addr_n   = '0;
      acnt_n   = '0;
      match_n  = 1'b0;
    end else if (sck_rise) begin
      if (!en_s) begin
        addr_n = {dat_s, addr_q[ADDR_W-1:1]};
        if (acnt_q != AC_DONE) acnt_n = acnt_q + AC_W'(1);
      end else if (match_q) begin
        if (bcnt_q < CNT_FULL) frame_n[bcnt_q[IDX_W-1:0]] = dat_s;
        if (bcnt_q != CNT_OVER) bcnt_n = bcnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      acnt_q   <= '0;
      match_q  <= 1'b0;
      bcnt_q   <= '0;
      frame_q  <= '0;
      commit_q <= 1'b0;
      full_q   <= 1'b0;
    end else begin
      addr_q   <= addr_n;
      acnt_q   <= acnt_n;
      match_q  <= match_n;
      bcnt_q   <= bcnt_n;
      frame_q  <= frame_n;
      commit_q <= commit_n;
      full_q   <= full_n;
    end
  end

  assign commit_o = commit_q;
  assign full_o   = full_q;
  assign frame_o  = frame_q;

  // R8
  bcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt_q <= CNT_OVER);

  // R1
  acnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acnt_q <= AC_DONE);

  // R1
  commit_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> $past(match_q));

  // R10
  commit_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> !en_d);

  // R10
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |=> !commit_q);

endmodule

// File: rtl/sdc_cmd_regs.sv
module sdc_cmd_regs
  import sdc_pkg::*;
#(
  parameter int FULL_LEN = 40,
  parameter int CMP_LEN  = 32,
  parameter int LO_W     = 28,
  parameter int HI_W     = 26
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 commit_i,
  input  logic                 full_i,
  input  logic [FULL_LEN-1:0]  frame_i,
  output logic [LO_W+HI_W-1:0] disp_o,
  output logic [2:0]           port_cfg_o,
  output logic                 duty_half_o,
  output logic [2:0]           frame_div_o,
  output logic                 ext_clk_o,
  output logic                 seg_off_o,
  output logic                 pwr_save_o,
  output logic                 compat_o
);

  localparam int CTL = LO_W + 1;

  logic [LO_W-1:0] lo_q, lo_n;
  logic [HI_W-1:0] hi_q, hi_n;
  sdc_ctrl_t       ctl_q, ctl_n;
  logic            cmp_q, cmp_n;
  logic            dir, ld_lo, ld_hi, ld_ctl, ld_cmp, duty_eff;

  assign dir    = full_i ? frame_i[FULL_LEN-1] : frame_i[CMP_LEN-1];
  assign ld_lo  = commit_i & ~dir;
  assign ld_hi  = commit_i & dir;
  assign ld_ctl = ld_lo & full_i;
  assign ld_cmp = ld_lo & ~full_i;

  always_comb begin
    lo_n  = ld_lo ? frame_i[LO_W-1:0] : lo_q;
    hi_n  = ld_hi ? frame_i[HI_W-1:0] : hi_q;
    ctl_n = ctl_q;
    cmp_n = cmp_q;
    if (ld_ctl) begin
      ctl_n.port_cfg  = frame_i[CTL+2:CTL];
      ctl_n.duty_half = frame_i[CTL+3];
      ctl_n.frame_div = frame_i[CTL+6:CTL+4];
      ctl_n.ext_clk   = frame_i[CTL+7];
      ctl_n.seg_off   = frame_i[CTL+8];
      ctl_n.pwr_save  = frame_i[CTL+9];
      cmp_n           = 1'b0;
    end else if (ld_cmp) begin
      ctl_n.pwr_save  = frame_i[LO_W];
      ctl_n.seg_off   = frame_i[LO_W+1];
      cmp_n           = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      ctl_q <= '0;
      cmp_q <= 1'b0;
    end else begin
      lo_q  <= lo_n;
      hi_q  <= hi_n;
      ctl_q <= ctl_n;
      cmp_q <= cmp_n;
    end
  end

  assign duty_eff    = cmp_q | ctl_q.duty_half;
  assign duty_half_o = duty_eff;
  assign port_cfg_o  = cmp_q ? 3'b000 : ctl_q.port_cfg;
  assign frame_div_o = cmp_q ? 3'b000 : ctl_q.frame_div;
  assign ext_clk_o   = cmp_q ? 1'b0   : ctl_q.ext_clk;
  assign seg_off_o   = ctl_q.seg_off;
  assign pwr_save_o  = ctl_q.pwr_save;
  assign compat_o    = cmp_q;
  assign disp_o      = {hi_q, lo_q[LO_W-1] & duty_eff, lo_q[LO_W-2:0]};

  // R3 R5
  hi_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && dir) |=> ($stable(lo_q) && $stable(ctl_q) && $stable(cmp_q)));

  // R4
  cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !full_i && !dir) |=> cmp_q);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ($stable(lo_q) && $stable(hi_q) && $stable(ctl_q) && $stable(cmp_q)));

endmodule

// File: rtl/ser_disp_cmd_rx.sv
module ser_disp_cmd_rx
  import sdc_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter logic [7:0] DEV_ADDR    = SDC_DEV_ADDR,
  parameter int         FULL_LEN    = 40,
  parameter int         CMP_LEN     = 32,
  parameter int         LO_W        = 28,
  parameter int         HI_W        = 26,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_en_i,
  input  logic                 ser_clk_i,
  input  logic                 ser_dat_i,
  output logic [LO_W+HI_W-1:0] disp_o,
  output logic [2:0]           port_cfg_o,
  output logic                 duty_half_o,
  output logic [2:0]           frame_div_o,
  output logic                 ext_clk_o,
  output logic                 seg_off_o,
  output logic                 pwr_save_o,
  output logic                 compat_o
);

  logic                rst_m_q, rst_s_q;
  logic [2:0]          sync_q;
  logic                commit, full;
  logic [FULL_LEN-1:0] frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  sdc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_s_q),
    .d_i   ({ser_en_i, ser_clk_i, ser_dat_i}),
    .q_o   (sync_q)
  );

  sdc_frame_rx #(
    .ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR), .FULL_LEN(FULL_LEN), .CMP_LEN(CMP_LEN)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_s_q),
    .en_s     (sync_q[2]),
    .sck_s    (sync_q[1]),
    .dat_s    (sync_q[0]),
    .commit_o (commit),
    .full_o   (full),
    .frame_o  (frame)
  );

  sdc_cmd_regs #(
    .FULL_LEN(FULL_LEN), .CMP_LEN(CMP_LEN), .LO_W(LO_W), .HI_W(HI_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_s_q),
    .commit_i    (commit),
    .full_i      (full),
    .frame_i     (frame),
    .disp_o      (disp_o),
    .port_cfg_o  (port_cfg_o),
    .duty_half_o (duty_half_o),
    .frame_div_o (frame_div_o),
    .ext_clk_o   (ext_clk_o),
    .seg_off_o   (seg_off_o),
    .pwr_save_o  (pwr_save_o),
    .compat_o    (compat_o)
  );

endmodule

// File: tb/ser_disp_cmd_rx_tb_top.sv
`timescale 1ns/1ps
module ser_disp_cmd_rx_tb_top;

  logic clk = 1'b0;
  logic rst_n, ce, cl, di;
  logic [53:0] disp;
  logic [2:0]  port_cfg, frame_div;
  logic        duty_half, ext_clk, seg_off, pwr_save, compat;

  always #2 clk = ~clk;

  ser_disp_cmd_rx dut_i (
    .clk(clk), .rst_n(rst_n), .ser_en_i(ce), .ser_clk_i(cl), .ser_dat_i(di),
    .disp_o(disp), .port_cfg_o(port_cfg), .duty_half_o(duty_half),
    .frame_div_o(frame_div), .ext_clk_o(ext_clk), .seg_off_o(seg_off),
    .pwr_save_o(pwr_save), .compat_o(compat)
  );

  typedef struct packed {
    logic [53:0] disp;
    logic [2:0]  port;
    logic        duty;
    logic [2:0]  div;
    logic        ext, seg, pwr, cmp;
  } snap_t;

  snap_t exp_q[$];
  string tag_q[$];
  event  chk_ev;
  int    checks = 0, failures = 0;
  bit    done = 1'b0;

  // model state
  logic [27:0] m_lo = '0;
  logic [25:0] m_hi = '0;
  logic [2:0]  m_port = '0, m_div = '0;
  logic        m_duty = 0, m_ext = 0, m_seg = 0, m_pwr = 0, m_cmp = 0;

  function automatic snap_t model_snap();
    snap_t s;
    logic d;
    d = m_cmp | m_duty;
    s.disp = {m_hi, m_lo[27] & d, m_lo[26:0]};
    s.port = m_cmp ? 3'b000 : m_port;
    s.duty = d;
    s.div  = m_cmp ? 3'b000 : m_div;
    s.ext  = m_cmp ? 1'b0 : m_ext;
    s.seg  = m_seg;
    s.pwr  = m_pwr;
    s.cmp  = m_cmp;
    return s;
  endfunction

  function automatic void model_apply(logic [7:0] a, logic [39:0] f, int len);
    if (a != 8'h44) return;
    if (len == 40) begin
      if (f[39]) m_hi = f[25:0];
      else begin
        m_lo = f[27:0]; m_port = f[31:29]; m_duty = f[32]; m_div = f[35:33];
        m_ext = f[36]; m_seg = f[37]; m_pwr = f[38]; m_cmp = 1'b0;
      end
    end else if (len == 32) begin
      if (f[31]) m_hi = f[25:0];
      else begin
        m_lo = f[27:0]; m_pwr = f[28]; m_seg = f[29]; m_cmp = 1'b1;
      end
    end
  endfunction

  function automatic logic [39:0] full_lo(logic [27:0] lo, logic [2:0] p, logic dt,
                                          logic [2:0] fc, logic oc, logic sc, logic bu);
    return {1'b0, bu, sc, oc, fc, dt, p, 1'b0, lo};
  endfunction
  function automatic logic [39:0] full_hi(logic [25:0] hi);
    return {1'b1, 13'd0, hi};
  endfunction
  function automatic logic [39:0] cmp_lo(logic [27:0] lo, logic bu, logic sc);
    return {8'd0, 1'b0, 1'b0, sc, bu, lo};
  endfunction
  function automatic logic [39:0] cmp_hi(logic [25:0] hi);
    return {8'd0, 1'b1, 5'd0, hi};
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_check(string tag);
    exp_q.push_back(model_snap());
    tag_q.push_back(tag);
    ->chk_ev;
    #0;
  endtask

  task automatic tx_bit(logic b, bit idle_hi);
    if (!idle_hi) begin
      di = b; wait_clk(8); cl = 1'b1; wait_clk(8); cl = 1'b0;
    end else begin
      cl = 1'b0; di = b; wait_clk(8); cl = 1'b1; wait_clk(8);
    end
  endtask

  // Driver: sends one transfer, then queues the expected output state.
  task automatic send(logic [7:0] a, logic [39:0] f, int len, bit idle_hi,
                      bit pre_chk, string tag);
    cl = idle_hi; wait_clk(8);
    for (int i = 0; i < 8; i++) tx_bit(a[i], idle_hi);
    wait_clk(8);
    ce = 1'b1; wait_clk(8);
    for (int i = 0; i < len; i++) tx_bit((i < 40) ? f[i] : 1'b0, idle_hi);
    if (pre_chk) begin
      wait_clk(20);
      push_check("R10 before enable falls");
    end
    wait_clk(8);
    ce = 1'b0;
    wait_clk(20);
    model_apply(a, f, len);
    push_check(tag);
  endtask

  // Monitor: compares outputs against queued expectations.
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        snap_t e, act;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        act = {disp, port_cfg, duty_half, frame_div, ext_clk, seg_off, pwr_save, compat};
        checks++;
        if (act !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", t, act, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ce = 1'b0; cl = 1'b0; di = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    push_check("R11 reset state");

    send(8'h44, full_lo(28'hA5C3F0E, 3'b011, 1'b1, 3'b101, 1'b1, 1'b0, 1'b1), 40, 1'b0, 1'b1, "R2 full lower frame");
    send(8'h44, full_hi(26'h2B4D1C7), 40, 1'b0, 1'b0, "R3 full upper frame");
    send(8'h45, full_lo(28'h1111111, 3'b100, 1'b0, 3'b010, 1'b0, 1'b1, 1'b0), 40, 1'b0, 1'b0, "R1 wrong address ignored");
    send(8'h22, full_hi(26'h0000001), 40, 1'b0, 1'b0, "R1 bit-reversed address ignored");
    send(8'h44, full_lo(28'h2222222, 3'b001, 1'b0, 3'b111, 1'b0, 1'b1, 1'b0), 39, 1'b0, 1'b0, "R8 short frame discarded");
    send(8'h44, full_hi(26'h3FFFFFF), 41, 1'b0, 1'b0, "R8 long frame discarded");
    send(8'h44, full_lo(28'h8123456, 3'b100, 1'b0, 3'b110, 1'b0, 1'b1, 1'b0), 40, 1'b1, 1'b1, "R9 R7 idle-high clock, static masks D28");
    send(8'h44, full_hi(26'h155AA33), 40, 1'b1, 1'b0, "R9 idle-high upper frame");
    send(8'h44, cmp_lo(28'hFE01B2C, 1'b1, 1'b1), 32, 1'b0, 1'b0, "R4 R6 compat lower frame forces controls");
    send(8'h44, cmp_hi(26'h3000F0F), 32, 1'b1, 1'b0, "R5 compat upper frame");
    send(8'h44, cmp_lo(28'h0000000, 1'b0, 1'b0), 33, 1'b0, 1'b0, "R8 compat-length plus one discarded");
    send(8'h44, full_lo(28'h0F0F0F1, 3'b010, 1'b1, 3'b001, 1'b1, 1'b0, 1'b0), 40, 1'b0, 1'b0, "R4 full frame clears compat");
    send(8'h44, full_lo(28'h8000000, 3'b000, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0), 40, 1'b1, 1'b0, "R7 static hides D28");
    send(8'h44, full_lo(28'h8000000, 3'b000, 1'b1, 3'b000, 1'b0, 1'b0, 1'b0), 40, 1'b0, 1'b0, "R7 half duty shows D28");

    wait_clk(10);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule